// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four level-sensitive PCI interrupt request lines, named here PIRQ A, B, C and D, onto the sixteen inputs of a legacy interrupt controller. Each request line has its own byte-wide routing register. A routing value below 16 picks the controller input that the line drives. A value of 16 or more cuts the line off, so that it reaches no input. Any number of request lines may share one controller input, and the input is then the OR of their levels. Every controller output is a flop recomputed each clock from the live request levels and the current routing registers. After any change to a routing byte, all sixteen outputs therefore follow the new map on the next clock edge, with no stale level left behind.

Software programs the routing bytes through a byte write strobe, and reads them back through a combinational read port. Both ports use a byte offset. Two further helper ports are purely combinational. A route query reports whether a chosen request line is enabled and which input it targets. A slot swizzle turns a device slot number and its INTx pin into the index of the request line that the device's interrupt uses.

Top module: `pirq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four routing bytes become 0x80 (every line disabled) and `irq_out` becomes all zeros.
- R2: A write with `cfg_wr_en` high at offset 0x60+k stores `cfg_wdata` into the routing byte of line k (k=0 is line A, 3 is line D) at that edge. A read with `cfg_rd_addr` equal to 0x60+k returns the stored byte on `cfg_rdata` in the same cycle.
- R3: A write to any offset outside 0x60..0x63 changes no routing byte and no output. A read of such an offset returns 0x00.
- R4: When the routing byte of line k holds a value v below 16, `irq_out[v]` at an edge equals `pirq_in[k]` as sampled at that edge, so the output follows the input one clock later.
- R5: When the routing byte of line k holds 16 or more, line k has no effect on any bit of `irq_out`.
- R6: Each bit of `irq_out` is the OR of all enabled lines routed to it. When one of several lines sharing an input deasserts, the output stays high while any other sharing line is still high.
- R7: A routing byte written at edge E governs `irq_out` from edge E+1 on. If an asserted line is moved to a new target, the old output falls and the new one rises at the same edge, unless another line holds the old output.
- R8: For the line picked by `qry_sel` (0 = A to 3 = D), `qry_enabled` is 1 exactly when its routing byte is below 16. `qry_target` is then the low four bits of that byte, and 0 when the line is disabled.
- R9: `swz_pirq` equals (`swz_pin` + `swz_slot` − 1) modulo 4, where pin code 0 is INTA and 3 is INTD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Write byte offset |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rd_addr | input | 8 | Read byte offset |
| cfg_rdata | output | 8 | Read data byte, combinational |
| pirq_in | input | 4 | Request line levels, bit 0 = line A |
| irq_out | output | 16 | Registered controller input levels |
| qry_sel | input | 2 | Request line to query |
| qry_enabled | output | 1 | Queried line is routed |
| qry_target | output | 4 | Queried line's controller input |
| swz_slot | input | 5 | Device slot number |
| swz_pin | input | 2 | Device INTx pin, 0 = INTA |
| swz_pirq | output | 2 | Request line index for that pin |

## Verification
The bound checker checks several things on every cycle. It checks that each output equals the previous cycle's OR of routed live levels, which covers sharing, disabling and the one-clock lag. It checks that only a write to a line's own offset alters that line's routing byte, that the reset state is clean, and that the route query agrees with the stored bytes. Some behaviour appears only in the bench's scenarios: the edge at which a moved, asserted line hands its level from the old output to the new one, the zero returned by reads outside the window, and the slot swizzle over every slot and pin pairing.

// File: rtl/pirq_router_pkg.sv
// Shared constants and types of the interrupt line router.
// Assumes the line and input counts are fixed by the interrupt architecture.
package pirq_router_pkg;
    localparam int unsigned PIRQ_N     = 4;
    localparam int unsigned IRQ_N      = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned IRQ_IDX_W  = $clog2(IRQ_N);
    localparam int unsigned PIRQ_IDX_W = $clog2(PIRQ_N);

    // Decoded view of one routing byte.
    typedef struct packed {
        logic                 en;
        logic [IRQ_IDX_W-1:0] tgt;
    } route_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
// Routing byte storage with a byte write strobe and combinational read-back.
// Assumes one write per cycle; offsets outside the window are ignored.
module pirq_cfg_regs
    import pirq_router_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]  ROUTE_BASE  = 8'h60,
    parameter logic [BYTE_W-1:0]  ROUTE_RESET = 8'h80
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [BYTE_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [BYTE_W-1:0]                rd_data,
    output logic [PIRQ_N-1:0][BYTE_W-1:0]    routes
);
    logic [PIRQ_N-1:0] rd_hit;

    for (genvar k = 0; k < PIRQ_N; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ROUTE_BASE + ADDR_W'(k);

        // Hold or update the routing byte of line k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                routes[k] <= ROUTE_RESET;
            end else if (wr_en && (wr_addr == SLOT_ADDR)) begin
                routes[k] <= wr_data;
            end
        end

        assign rd_hit[k] = (rd_addr == SLOT_ADDR);
    end

    // Return the byte selected by the read offset, zero outside the window.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < PIRQ_N; k++) begin
            if (rd_hit[k]) begin
                rd_data = routes[k];
            end
        end
    end
endmodule

// File: rtl/pirq_route_decode.sv
// Decodes each routing byte into an enable and a target index, and serves
// the route query. Assumes values of IRQ_N or more mean disabled.
module pirq_route_decode
    import pirq_router_pkg::*;
(
    input  logic [PIRQ_N-1:0][BYTE_W-1:0] routes,
    input  logic [PIRQ_IDX_W-1:0]         qry_sel,
    output route_t [PIRQ_N-1:0]           dec,
    output logic                          qry_enabled,
    output logic [IRQ_IDX_W-1:0]          qry_target
);
    for (genvar k = 0; k < PIRQ_N; k++) begin : g_dec
        // Split one byte into enable flag and target index.
        always_comb begin
            dec[k].en  = (routes[k] < BYTE_W'(IRQ_N));
            dec[k].tgt = dec[k].en ? routes[k][IRQ_IDX_W-1:0] : '0;
        end
    end

    // Report the decoded route of the queried line.
    always_comb begin
        qry_enabled = dec[qry_sel].en;
        qry_target  = dec[qry_sel].tgt;
    end
endmodule

// File: rtl/pirq_irq_merge.sv
// ORs the live request levels onto their routed controller inputs and
// registers the result. Assumes routes are already decoded.
module pirq_irq_merge
    import pirq_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIRQ_N-1:0]    pirq_in,
    input  route_t [PIRQ_N-1:0]  dec,
    output logic [IRQ_N-1:0]     irq_out
);
    logic [IRQ_N-1:0] level_d;

    // Rebuild every output level from scratch out of the live inputs.
    always_comb begin
        level_d = '0;
        for (int j = 0; j < IRQ_N; j++) begin
            for (int k = 0; k < PIRQ_N; k++) begin
                if (pirq_in[k] && dec[k].en && (dec[k].tgt == IRQ_IDX_W'(j))) begin
                    level_d[j] = 1'b1;
                end
            end
        end
    end

    // Register the merged levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= '0;
        end else begin
            irq_out <= level_d;
        end
    end
endmodule

// File: rtl/pirq_swizzle.sv
// Maps a device slot and INTx pin to a request line index by rotation.
// Assumes pin code 0 is the first pin; purely combinational.
module pirq_swizzle
    import pirq_router_pkg::*;
#(
    parameter int unsigned SLOT_W = 5
) (
    input  logic [SLOT_W-1:0]     slot,
    input  logic [PIRQ_IDX_W-1:0] pin,
    output logic [PIRQ_IDX_W-1:0] pirq
);
    // Rotate the pin by slot minus one, modulo the line count.
    always_comb begin
        pirq = PIRQ_IDX_W'((32'(slot) + 32'(pin) + 32'(PIRQ_N - 1)) % PIRQ_N);
    end
endmodule

// File: rtl/pirq_router.sv
// Top of the interrupt line router: routing bytes, decode, merge, swizzle.
// Assumes a single clock and a synchronous active-low reset.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 8,
    parameter int unsigned        SLOT_W      = 5,
    parameter logic [ADDR_W-1:0]  ROUTE_BASE  = 8'h60,
    parameter logic [BYTE_W-1:0]  ROUTE_RESET = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [BYTE_W-1:0]     cfg_wdata,
    input  logic [ADDR_W-1:0]     cfg_rd_addr,
    output logic [BYTE_W-1:0]     cfg_rdata,
    input  logic [PIRQ_N-1:0]     pirq_in,
    output logic [IRQ_N-1:0]      irq_out,
    input  logic [PIRQ_IDX_W-1:0] qry_sel,
    output logic                  qry_enabled,
    output logic [IRQ_IDX_W-1:0]  qry_target,
    input  logic [SLOT_W-1:0]     swz_slot,
    input  logic [PIRQ_IDX_W-1:0] swz_pin,
    output logic [PIRQ_IDX_W-1:0] swz_pirq
);
    logic [PIRQ_N-1:0][BYTE_W-1:0] route_bytes;
    route_t [PIRQ_N-1:0]           route_dec;

    pirq_cfg_regs #(
        .ADDR_W      (ADDR_W),
        .ROUTE_BASE  (ROUTE_BASE),
        .ROUTE_RESET (ROUTE_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_addr (cfg_rd_addr),
        .rd_data (cfg_rdata),
        .routes  (route_bytes)
    );

    pirq_route_decode u_dec (
        .routes      (route_bytes),
        .qry_sel     (qry_sel),
        .dec         (route_dec),
        .qry_enabled (qry_enabled),
        .qry_target  (qry_target)
    );

    pirq_irq_merge u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pirq_in (pirq_in),
        .dec     (route_dec),
        .irq_out (irq_out)
    );

    pirq_swizzle #(
        .SLOT_W (SLOT_W)
    ) u_swz (
        .slot (swz_slot),
        .pin  (swz_pin),
        .pirq (swz_pirq)
    );
endmodule

// File: rtl/pirq_router_chk.sv
// Property checker for the interrupt line router, bound to its top.
// Assumes the routing bytes are visible through the bind connection.
module pirq_router_chk
    import pirq_router_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]  ROUTE_BASE  = 8'h60,
    parameter logic [BYTE_W-1:0]  ROUTE_RESET = 8'h80
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr_en,
    input logic [ADDR_W-1:0]             cfg_addr,
    input logic [BYTE_W-1:0]             cfg_wdata,
    input logic [PIRQ_N-1:0]             pirq_in,
    input logic [IRQ_N-1:0]              irq_out,
    input logic [PIRQ_IDX_W-1:0]         qry_sel,
    input logic                          qry_enabled,
    input logic [IRQ_IDX_W-1:0]          qry_target,
    input logic [PIRQ_N-1:0][BYTE_W-1:0] route_bytes
);
    logic [IRQ_N-1:0] want_next;

    // Expected next output levels from the stored bytes and the live inputs.
    always_comb begin
        want_next = '0;
        for (int k = 0; k < PIRQ_N; k++) begin
            if (pirq_in[k] && (int'(route_bytes[k]) < int'(IRQ_N))) begin
                want_next[route_bytes[k][IRQ_IDX_W-1:0]] = 1'b1;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0));

    for (genvar k = 0; k < PIRQ_N; k++) begin : g_byte
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ROUTE_BASE + ADDR_W'(k);

        // R1
        reset_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (route_bytes[k] == ROUTE_RESET));

        // R2
        write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_addr == SLOT_ADDR) |=> (route_bytes[k] == $past(cfg_wdata)));

        // R3
        write_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr_en && cfg_addr == SLOT_ADDR) |=> $stable(route_bytes[k]));
    end

    // R6
    merge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!rst_n) |-> (irq_out == $past(want_next)));

    // R8
    query_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_enabled == (int'(route_bytes[qry_sel]) < int'(IRQ_N)));

    // R8
    query_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_target == (qry_enabled ? route_bytes[qry_sel][IRQ_IDX_W-1:0] : '0));
endmodule

bind pirq_router pirq_router_chk #(
    .ADDR_W      (ADDR_W),
    .ROUTE_BASE  (ROUTE_BASE),
    .ROUTE_RESET (ROUTE_RESET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .pirq_in     (pirq_in),
    .irq_out     (irq_out),
    .qry_sel     (qry_sel),
    .qry_enabled (qry_enabled),
    .qry_target  (qry_target),
    .route_bytes (route_bytes)
);

// File: tb/sim_pirq_router.sv
module sim_pirq_router;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pirq_in = '0;
    logic [15:0] irq_out;
    logic [1:0]  qry_sel = '0;
    logic        qry_enabled;
    logic [3:0]  qry_target;
    logic [4:0]  swz_slot = '0;
    logic [1:0]  swz_pin = '0;
    logic [1:0]  swz_pirq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    int          m_route[4];
    logic [15:0] m_irq = '0;

    pirq_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
        .pirq_in(pirq_in), .irq_out(irq_out), .qry_sel(qry_sel),
        .qry_enabled(qry_enabled), .qry_target(qry_target), .swz_slot(swz_slot),
        .swz_pin(swz_pin), .swz_pirq(swz_pirq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model stepped on each edge, compared shortly after it (R4).
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_route[k]) m_route[k] = 'h80;
            m_irq = '0;
        end else begin
            logic [15:0] nxt;
            nxt = '0;
            for (int k = 0; k < 4; k++)
                if (pirq_in[k] && m_route[k] < 16) nxt[m_route[k]] = 1'b1;
            m_irq = nxt;
            if (cfg_wr_en)
                for (int k = 0; k < 4; k++)
                    if (int'(cfg_addr) == 'h60 + k) m_route[k] = int'(cfg_wdata);
        end
        #2;
        if (!done) check("R4 per-cycle irq_out", int'(irq_out), int'(m_irq));
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input int exp);
        cfg_rd_addr = a;
        #1;
        check(req, int'(cfg_rdata), exp);
    endtask

    task automatic summary;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        pirq_in = 4'hF;
        tick(3);
        // R1: reset state with every line asserted
        for (int k = 0; k < 4; k++) rd("R1 reset byte", 8'(8'h60 + k), 'h80);
        check("R1 irq_out after reset", int'(irq_out), 0);
        rst_n = 1'b1;
        tick(2);
        check("R5 all disabled, lines high", int'(irq_out), 0);
        pirq_in = '0;

        // R2: program line A to input 5 and read back
        wr(8'h60, 8'h05);
        rd("R2 readback A", 8'h60, 'h05);
        pirq_in[0] = 1'b1;
        tick(1);
        check("R4 A routed to 5", int'(irq_out), 'h0020);

        // R6: share input 5 among A, B, C
        wr(8'h61, 8'h05);
        wr(8'h62, 8'h05);
        pirq_in = 4'b0111;
        tick(2);
        pirq_in[0] = 1'b0;
        tick(1);
        check("R6 shared stays high after A drops", int'(irq_out[5]), 1);
        pirq_in[1] = 1'b0;
        tick(1);
        check("R6 shared held by C", int'(irq_out[5]), 1);

        // R7: move asserted C from 5 to 9
        wr(8'h62, 8'h09);
        check("R7 old route until next edge", int'(irq_out), 'h0020);
        tick(1);
        check("R7 old output falls", int'(irq_out[5]), 0);
        check("R7 new output rises", int'(irq_out[9]), 1);
        pirq_in[2] = 1'b0;
        tick(1);
        check("R6 all released", int'(irq_out), 0);

        // R5: disable D while asserted, with threshold value 16 and 0xFF
        wr(8'h63, 8'h0F);
        pirq_in[3] = 1'b1;
        tick(1);
        check("R4 D routed to 15", int'(irq_out), 'h8000);
        wr(8'h63, 8'h10);
        tick(1);
        check("R5 value 16 disables D", int'(irq_out), 0);
        wr(8'h63, 8'hFF);
        tick(1);
        check("R5 value 0xFF disables D", int'(irq_out), 0);

        // R3: writes just outside the window change nothing
        wr(8'h5F, 8'h03);
        wr(8'h64, 8'h03);
        wr(8'h00, 8'h03);
        tick(1);
        rd("R3 byte A unchanged", 8'h60, 'h05);
        rd("R3 byte B unchanged", 8'h61, 'h05);
        rd("R3 byte C unchanged", 8'h62, 'h09);
        rd("R3 byte D unchanged", 8'h63, 'hFF);
        check("R3 no output change", int'(irq_out), 0);
        rd("R3 read above window", 8'h64, 0);
        rd("R3 read below window", 8'h5F, 0);
        pirq_in[3] = 1'b0;

        // R8: route query over enabled and disabled lines
        wr(8'h61, 8'h00);
        for (int k = 0; k < 4; k++) begin
            int exp_en;
            int exp_t;
            qry_sel = 2'(k);
            #1;
            exp_en = (m_route[k] < 16) ? 1 : 0;
            exp_t  = exp_en ? m_route[k] : 0;
            check("R8 query enabled", int'(qry_enabled), exp_en);
            check("R8 query target", int'(qry_target), exp_t);
        end

        // R9: swizzle over every slot and pin
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                swz_slot = 5'(s);
                swz_pin = 2'(p);
                #1;
                check("R9 swizzle", int'(swz_pirq), (p + s + 3) % 4);
            end
        end

        // R1: reset in mid-run clears routes and outputs
        pirq_in = 4'hF;
        tick(1);
        rst_n = 1'b0;
        tick(1);
        check("R1 outputs cleared", int'(irq_out), 0);
        rd("R1 byte A back to reset", 8'h60, 'h80);
        rst_n = 1'b1;
        tick(2);
        summary();
    end
endmodule